// File: doc/BRIEF.md
# Parallel/Serial Gate Combiner

This block produces the gate-enable signals of a four-channel low-side driver. Each channel's enable is the result of one Boolean operator applied to two sources. The first source is a parallel control pin. A program input sets whether that pin is active-high or active-low. The second source is a data bit that was latched from a serial command word. The serial command also chooses the operator. OR lets the serial bit force a channel on. AND lets the serial bit force a channel off. The chosen operator stays in force until the opposite command arrives. After reset the operator is OR and the serial data are all zero.

Each command word is presented to the block for one clock together with a strobe. This happens once the serial transfer has completed. Two control words load the data and select the operator. Every other control word (diagnosis, read-back, echo or an unknown code) leaves the data and the operator untouched. A pin can be reported as unconnected. Such a pin counts as inactive whatever its level. A per-channel overtemperature flag puts that channel into a restart pattern. While the flag is high, the channel is held off except for one tick period in every sixteen.

Top module: `oc_gate_combiner`

## Requirements
- R1: While `rst_n` is low, every bit of `gate_en` is 0. After release, the serial data are 0000 and the operator is OR, so `gate_en` equals the active parallel pins.
- R2: With `prg` high a parallel pin is active when it is 1. With `prg` low a pin is active when it is 0.
- R3: In OR mode, `gate_en[i]` is (active pin i) OR (data bit i). A change on a parallel pin reaches `gate_en` one clock later. A loaded command reaches it two clocks after the strobe edge.
- R4: In AND mode, `gate_en[i]` is (active pin i) AND (data bit i).
- R5: `cmd_word[7:4]` is the control field and `cmd_word[3:0]` holds data bits 3..0 for channels 3..0. Control 4'b0011 loads the data and selects OR. Control 4'b1111 loads the data and selects AND.
- R6: A strobed word with any other control field changes neither the data nor the operator. This includes 4'b0000, 4'b1100 and 4'b1010.
- R7: The operator stays latched through idle cycles and through other commands until the opposite load command arrives.
- R8: When `par_open[i]` is 1, parallel pin i counts as inactive at either polarity.
- R9: While `ot_flag[i]` is high, `gate_en[i]` is 0 except during one tick period out of every 16. Each tick is TICK_DIV clocks long, 8 by default. The off phase comes first. Once the flag clears, the channel follows R3/R4 on the next clock and the pattern starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| prg | input | 1 | Parallel pin polarity: 1 active-high, 0 active-low |
| par_in | input | 4 | Parallel control pins, bit i for channel i |
| par_open | input | 4 | Pin i is unconnected and taken as inactive |
| cmd_valid | input | 1 | One-clock strobe for a completed command word |
| cmd_word | input | 8 | Control field [7:4], data field [3:0] |
| ot_flag | input | 4 | Per-channel overtemperature flag |
| gate_en | output | 4 | Registered per-channel gate enable |

## Verification
A command strobe can land in the same clock as a change on the parallel pins. The bench provokes this by driving a new pin pattern and a load command on the same falling edge. It then checks `gate_en` on both following clocks. The first clock must show the new pins combined with the old data. The second must show the new pins combined with the new data and operator. The restart window and an operator change can also meet. The thermal test therefore runs with a loaded data pattern and measures the exact number of on-clocks over two full restart periods. Meanwhile a neighbouring channel must keep following its combined value.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;
  localparam int CTRL_W = 4;

  typedef enum logic {OP_OR = 1'b0, OP_AND = 1'b1} op_e;

  typedef enum logic [2:0] {
    CK_DIAG, CK_READBACK, CK_ECHO, CK_OR, CK_AND, CK_OTHER
  } cmd_kind_e;

  // Control field classification; only CK_OR and CK_AND touch state.
  function automatic cmd_kind_e decode_ctrl(input logic [CTRL_W-1:0] c);
    cmd_kind_e k;
    case (c)
      4'b0000: k = CK_DIAG;
      4'b1100: k = CK_READBACK;
      4'b1010: k = CK_ECHO;
      4'b0011: k = CK_OR;
      4'b1111: k = CK_AND;
      default: k = CK_OTHER;
    endcase
    return k;
  endfunction

  // Normalise a parallel pin to "channel requested on".
  function automatic logic pin_active(input logic pin, input logic prg,
                                      input logic unconnected);
    if (unconnected) return 1'b0;
    return prg ? pin : ~pin;
  endfunction

  // Merge the parallel request with the serial bit.
  function automatic logic combine(input logic act, input logic dat,
                                   input op_e op);
    return (op == OP_AND) ? (act & dat) : (act | dat);
  endfunction
endpackage

// File: rtl/oc_tick_gen.sv
`timescale 1ns/1ps
module oc_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (cnt == W'(DIV - 1)) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == W'(DIV - 1));

      // R9: ticks are isolated single-clock pulses
      a_r9_tick_sparse: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/oc_cmd_latch.sv
`timescale 1ns/1ps
module oc_cmd_latch
  import oc_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [CTRL_W+NCH-1:0] cmd_word,
  output logic [NCH-1:0]        data_q,
  output op_e                   op_q
);
  localparam int CMD_W = CTRL_W + NCH;

  cmd_kind_e kind;
  logic      load_evt;

  assign kind     = decode_ctrl(cmd_word[CMD_W-1 -: CTRL_W]);
  assign load_evt = cmd_valid && ((kind == CK_OR) || (kind == CK_AND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      op_q   <= OP_OR;
    end else if (load_evt) begin
      data_q <= cmd_word[NCH-1:0];
      op_q   <= (kind == CK_AND) ? OP_AND : OP_OR;
    end
  end

  // R6: non-loading commands keep data and operator
  a_r6_hold_other: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !load_evt) |=> ($stable(data_q) && $stable(op_q)));

  // R7: operator only moves on a strobe
  a_r7_op_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(op_q));

  // R5: AND load takes the data field and the operator
  a_r5_and_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (kind == CK_AND)) |=>
      ((op_q == OP_AND) && (data_q == $past(cmd_word[NCH-1:0]))));
endmodule

// File: rtl/oc_thermal_restart.sv
`timescale 1ns/1ps
module oc_thermal_restart #(
  parameter int NCH    = 4,
  parameter int PHASES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NCH-1:0] ot_flag,
  output logic [NCH-1:0] allow
);
  localparam int PW = $clog2(PHASES);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [PW-1:0] phase;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase <= '0;
        else if (!ot_flag[ch]) phase <= '0;
        else if (tick)         phase <= (phase == LAST) ? '0 : phase + 1'b1;
      end
      // Off phases first, the last phase of each cycle is the restart window.
      assign allow[ch] = !ot_flag[ch] || (phase == LAST);

      // R9: a restart window lasts one tick only
      a_r9_one_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag[ch] && allow[ch] && tick) |=> (!allow[ch] || !ot_flag[ch]));
    end
  endgenerate
endmodule

// File: rtl/oc_gate_combiner.sv
`timescale 1ns/1ps
module oc_gate_combiner
  import oc_pkg::*;
#(
  parameter int NCH            = 4,
  parameter int TICK_DIV       = 8,
  parameter int RESTART_PHASES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prg,
  input  logic [NCH-1:0]        par_in,
  input  logic [NCH-1:0]        par_open,
  input  logic                  cmd_valid,
  input  logic [CTRL_W+NCH-1:0] cmd_word,
  input  logic [NCH-1:0]        ot_flag,
  output logic [NCH-1:0]        gate_en
);
  logic [NCH-1:0] data_q;
  op_e            op_q;
  logic           tick;
  logic [NCH-1:0] allow;
  logic [NCH-1:0] par_act;
  logic [NCH-1:0] comb_on;

  oc_cmd_latch #(.NCH(NCH)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .data_q(data_q), .op_q(op_q)
  );

  oc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  oc_thermal_restart #(.NCH(NCH), .PHASES(RESTART_PHASES)) u_therm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ot_flag(ot_flag), .allow(allow)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_out
      assign par_act[ch] = pin_active(par_in[ch], prg, par_open[ch]);
      assign comb_on[ch] = combine(par_act[ch], data_q[ch], op_q);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_en[ch] <= 1'b0;
        else        gate_en[ch] <= comb_on[ch] & allow[ch];
      end

      // R4: AND mode with a cleared serial bit keeps the channel off
      a_r4_and_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_q == OP_AND) && !data_q[ch]) |=> !gate_en[ch]);

      // R3: OR mode with a set serial bit turns the channel on
      a_r3_or_on: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_q == OP_OR) && data_q[ch] && allow[ch]) |=> gate_en[ch]);

      // R9: outside the restart window an overheated channel is off
      a_r9_hot_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag[ch] && !allow[ch]) |=> !gate_en[ch]);
    end
  endgenerate
endmodule

// File: tb/test_oc_gate_combiner.sv
`timescale 1ns/1ps
module test_oc_gate_combiner;
  localparam int NCH      = 4;
  localparam int TICK_DIV = 8;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prg = 1'b1;
  logic [3:0] par_in = '0;
  logic [3:0] par_open = '0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_word = '0;
  logic [3:0] ot_flag = '0;
  logic [3:0] gate_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side model state
  logic [3:0] m_data = '0;
  bit         m_and  = 0;

  always #4 clk = ~clk;

  oc_gate_combiner i_oc_gate_combiner (
    .clk(clk), .rst_n(rst_n), .prg(prg), .par_in(par_in),
    .par_open(par_open), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .ot_flag(ot_flag), .gate_en(gate_en)
  );

  function automatic logic [3:0] expect_gate();
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      logic a;
      a = par_open[i] ? 1'b0 : (prg ? par_in[i] : !par_in[i]);
      r[i] = m_and ? (a && m_data[i]) : (a || m_data[i]);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [3:0] got,
                       input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: gate_en=%b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] w);
    cmd_word  = w;
    cmd_valid = 1'b1;
    step(1);
    cmd_valid = 1'b0;
    if (w[7:4] == 4'b0011) begin m_data = w[3:0]; m_and = 0; end
    if (w[7:4] == 4'b1111) begin m_data = w[3:0]; m_and = 1; end
    step(1);
  endtask

  task automatic t_reset();
    prg = 1'b1; par_in = 4'b1111;
    step(3);
    check("R1 reset holds off", gate_en, 4'b0000);
    rst_n = 1'b1; par_in = 4'b0000;
    step(2);
    check("R1 cleared data", gate_en, 4'b0000);
    par_in = 4'b0101;
    step(1);
    check("R1 default OR", gate_en, 4'b0101);
  endtask

  task automatic t_polarity();
    prg = 1'b0; par_in = 4'b1010;
    step(1);
    check("R2 active-low", gate_en, 4'b0101);
    prg = 1'b1;
    step(1);
    check("R2 active-high", gate_en, 4'b1010);
  endtask

  task automatic t_or();
    send(8'b0011_0011);
    par_in = 4'b0100;
    step(1);
    check("R3 R5 OR merge", gate_en, expect_gate());
    check("R3 OR value", gate_en, 4'b0111);
  endtask

  task automatic t_and();
    send(8'b1111_0110);
    par_in = 4'b1100;
    step(1);
    check("R4 R5 AND merge", gate_en, 4'b0100);
    par_in = 4'b1111;
    step(1);
    check("R4 AND full pins", gate_en, 4'b0110);
  endtask

  task automatic t_ignore();
    logic [7:0] words [4] = '{8'b0000_1111, 8'b1100_1111,
                              8'b1010_1111, 8'b0111_1001};
    for (int k = 0; k < 4; k++) begin
      par_in = 4'b1111;
      send(words[k]);
      check("R6 data kept", gate_en, 4'b0110);
      par_in = 4'b0000;
      step(1);
      check("R6 operator kept", gate_en, 4'b0000);
    end
  endtask

  task automatic t_latch();
    par_in = 4'b1001;
    step(20);
    check("R7 AND persists", gate_en, 4'b0000);
    send(8'b0011_0000);
    check("R7 OR after switch", gate_en, 4'b1001);
  endtask

  task automatic t_open();
    par_open = 4'b0011; prg = 1'b0; par_in = 4'b0000;
    step(1);
    check("R8 open low-active", gate_en, 4'b1100);
    prg = 1'b1; par_in = 4'b1111;
    step(1);
    check("R8 open high-active", gate_en, 4'b1100);
    par_open = 4'b0000;
  endtask

  task automatic t_concurrent();
    par_in    = 4'b0011;
    cmd_word  = 8'b1111_1010;
    cmd_valid = 1'b1;
    step(1);
    cmd_valid = 1'b0;
    check("R3 same-cycle pins old data", gate_en, 4'b0011);
    m_data = 4'b1010; m_and = 1;
    step(1);
    check("R4 same-cycle new command", gate_en, 4'b0010);
  endtask

  task automatic t_thermal();
    int highs;
    bit early_on;
    bit neigh_bad;
    send(8'b0011_0000);
    par_in = 4'b0011;
    step(1);
    check("R9 before flag", gate_en, 4'b0011);
    ot_flag = 4'b0001;
    step(1);
    check("R9 off at once", gate_en, 4'b0010);
    early_on = 0;
    for (int c = 0; c < 100; c++) begin
      step(1);
      if (gate_en[0]) early_on = 1;
    end
    check("R9 off phase first", {3'b000, early_on}, 4'b0000);
    highs = 0; neigh_bad = 0;
    for (int c = 0; c < 32 * TICK_DIV; c++) begin
      step(1);
      if (gate_en[0]) highs++;
      if (!gate_en[1]) neigh_bad = 1;
    end
    check("R9 duty count", highs[3:0] ^ 4'(highs >> 4), 4'(2 * TICK_DIV) ^ 4'((2 * TICK_DIV) >> 4));
    if (highs != 2 * TICK_DIV) begin
      fails++;
      $display("FAIL R9 on-clocks=%0d expected %0d", highs, 2 * TICK_DIV);
    end
    check("R9 neighbour unaffected", {3'b000, neigh_bad}, 4'b0000);
    ot_flag = 4'b0000;
    step(1);
    check("R9 release", gate_en, 4'b0011);
    ot_flag = 4'b0001;
    step(1);
    check("R9 restart off", gate_en, 4'b0010);
    ot_flag = 4'b0000;
    step(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
    end
  endtask

  initial begin
    step(1);
    t_reset();
    t_polarity();
    t_or();
    t_and();
    t_ignore();
    t_latch();
    t_open();
    t_concurrent();
    t_thermal();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    finish_run();
  end
endmodule